// File: doc/BRIEF.md
# Periodic Interval Timer with Wrap Counter

The block is a free-running interval timer for a system-on-chip. A prescaler divides the system clock by a fixed ratio of sixteen. Each prescaled tick advances a 20-bit current-value counter. The counter runs from 0 up to a programmed limit N, then returns to 0, so one period is N+1 ticks. Each return to 0 (a wrap) sets a sticky status flag. It also adds one to a 12-bit wrap counter, so software that services the timer late still learns how many periods went by. The status flag, gated by an interrupt enable, drives an active-high interrupt line.

Software uses a small register bus with single-cycle accesses. Writes take effect on the clock edge where the write strobe is high. Read data is combinational while the read strobe is high. There is no back-pressure: every access completes in the cycle it is issued. Two read-only registers return the same {wrap count, current value} word. One of them acknowledges the timer on read: it clears the wrap count and the status flag. The other is a side-effect-free image of the same word, meant for timekeeping reads.

Clearing the enable does not stop the counter at once. The counter finishes its current period, reaches 0 and then holds there. Software can poll for a zero value to confirm that the timer has stopped.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The mode register at byte offset 0x0 holds the limit N in bits 19:0, the timer enable in bit 24 and the interrupt enable in bit 25. It reads back what was written, and all other bits read 0.
- R3: While the timer runs, the current value advances once every 16 clocks. When the enable goes from 0 to 1, the prescaler restarts from 0, so the first advance comes 16 clocks after the enabling write.
- R4: The current value counts 0..N and wraps to 0 on the tick after it reaches N. If N is lowered below the current value, the next tick wraps to 0.
- R5: The acknowledging value register at 0xC-4 = 0x8 and the image register at 0xC both return the wrap count in bits 31:20 and the current value in bits 19:0.
- R6: A read of 0x8 clears the wrap count and the status flag at that clock edge. A read of 0xC changes nothing.
- R7: Status register 0x4 bit 0 is set on every wrap and stays set until it is acknowledged. Its other bits read 0.
- R8: `irq` equals (status AND interrupt enable) delayed by one clock.
- R9: The wrap count saturates at 4095 and does not roll over.
- R10: If a wrap and an acknowledging read fall on the same clock edge, the status stays set and the wrap count becomes 1.
- R11: After the enable is cleared, the current value keeps advancing until it wraps to 0 (that wrap sets status), then holds at 0.
- R12: Writes to 0x4, 0x8 and 0xC, and any access whose address bits 1:0 are not zero, have no effect. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a value-register read acknowledges the timer |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| irq | output | 1 | Registered, active-high interrupt request |

## Verification
The bound assertions check these behaviours on every cycle:
- the current value changes only on a prescaled tick;
- a tick at the limit returns the value to 0;
- a stopped timer holds at 0;
- a wrap always leaves status set;
- a wrap colliding with an acknowledge leaves a count of 1;
- a saturated count stays at its maximum;
- `irq` follows the gated status one cycle later.

Only the bench scenarios can show the end-to-end sequences:
- the sixteen-clock spacing after an enabling write;
- the drain-and-hold after the enable is cleared;
- the image read that leaves state untouched;
- saturation after more than four thousand unacknowledged periods;
- ignored writes, shown through later reads.

// File: rtl/itt_pkg.sv
package itt_pkg;

  // Register select, taken from byte address bits 3:2
  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_VALUE = 2'd2,
    SEL_IMAGE = 2'd3
  } itt_sel_e;

  // Mode register control bit positions
  localparam int unsigned RUN_BIT = 24;
  localparam int unsigned IEN_BIT = 25;

endpackage

// File: rtl/itt_prescale.sv
module itt_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run || restart) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/itt_period_cnt.sv
module itt_period_cnt #(
  parameter int unsigned VAL_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [VAL_W-1:0] limit,
  output logic [VAL_W-1:0] value,
  output logic             wrap
);
  // At or beyond the limit, the next tick returns the value to zero
  assign wrap = tick && (value >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wrap) begin
      value <= '0;
    end else if (tick) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/itt_wrap_track.sv
module itt_wrap_track #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             ack,
  input  logic             ien,
  output logic             status,
  output logic [CNT_W-1:0] wraps,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      wraps  <= '0;
    end else if (wrap) begin
      // A wrap outranks a simultaneous acknowledge
      status <= 1'b1;
      if (ack) begin
        wraps <= CNT_W'(1);
      end else if (wraps != CNT_MAX) begin
        wraps <= wraps + 1'b1;
      end
    end else if (ack) begin
      status <= 1'b0;
      wraps  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= status & ien;
    end
  end
endmodule

// File: rtl/itt_regs.sv
module itt_regs
  import itt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VAL_W  = 20,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic [VAL_W-1:0]  value,
  input  logic [CNT_W-1:0]  wraps,
  input  logic              status,
  output logic [VAL_W-1:0]  limit,
  output logic              run_en,
  output logic              ien,
  output logic              run_rise,
  output logic              ack
);
  localparam logic [DATA_W-1:0] MODE_MASK =
    (DATA_W'(1) << IEN_BIT) | (DATA_W'(1) << RUN_BIT) | ((DATA_W'(1) << VAL_W) - 1'b1);

  itt_sel_e    sel;
  logic        hit;
  logic        wr_mode;
  logic [DATA_W-1:0] unused_wbits;
  logic [DATA_W-1:0] mode_word;
  logic [DATA_W-1:0] tally_word;

  assign sel     = itt_sel_e'(addr[3:2]);
  assign hit     = (addr[1:0] == 2'b00) && ((addr >> 4) == '0);
  assign wr_mode = wr && hit && (sel == SEL_MODE);
  assign ack     = rd && hit && (sel == SEL_VALUE);
  assign run_rise = wr_mode && wdata[RUN_BIT] && !run_en;
  assign unused_wbits = wdata & ~MODE_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit  <= '0;
      run_en <= 1'b0;
      ien    <= 1'b0;
    end else if (wr_mode) begin
      limit  <= wdata[VAL_W-1:0];
      run_en <= wdata[RUN_BIT];
      ien    <= wdata[IEN_BIT];
    end
  end

  assign mode_word  = (DATA_W'(ien) << IEN_BIT) | (DATA_W'(run_en) << RUN_BIT)
                    | DATA_W'(limit);
  assign tally_word = (DATA_W'(wraps) << VAL_W) | DATA_W'(value);

  always_comb begin
    rdata = '0;
    if (rd && hit) begin
      unique case (sel)
        SEL_MODE:  rdata = mode_word;
        SEL_STAT:  rdata = DATA_W'(status);
        SEL_VALUE: rdata = tally_word;
        SEL_IMAGE: rdata = tally_word;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned VAL_W    = 20,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [VAL_W-1:0] limit;
  logic [VAL_W-1:0] cur_val;
  logic [CNT_W-1:0] wrap_cnt;
  logic             run_en;
  logic             ien;
  logic             run_rise;
  logic             ack;
  logic             running;
  logic             tick;
  logic             wrap;
  logic             status;

  // A cleared enable still runs until the period completes at zero
  assign running = run_en || (cur_val != '0);

  itt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .rdata(bus_rdata),
    .value(cur_val), .wraps(wrap_cnt), .status(status),
    .limit(limit), .run_en(run_en), .ien(ien),
    .run_rise(run_rise), .ack(ack)
  );

  itt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(run_rise), .tick(tick)
  );

  itt_period_cnt #(.VAL_W(VAL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .limit(limit),
    .value(cur_val), .wrap(wrap)
  );

  itt_wrap_track #(.CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack), .ien(ien),
    .status(status), .wraps(wrap_cnt), .irq(irq)
  );
endmodule

// File: rtl/itt_checker.sv
module itt_checker #(
  parameter int unsigned VAL_W = 20,
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap,
  input logic             ack,
  input logic             run_en,
  input logic             ien,
  input logic             status,
  input logic [VAL_W-1:0] cur_val,
  input logic [VAL_W-1:0] limit,
  input logic [CNT_W-1:0] wrap_cnt,
  input logic             irq
);
  // R3
  value_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (cur_val == $past(cur_val)));

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cur_val >= limit)) |=> (cur_val == '0));

  // R11
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && (cur_val == '0)) |=> (cur_val == '0));

  // R7
  wrap_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> status);

  // R10
  wrap_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ack) |=> (wrap_cnt == CNT_W'(1)));

  // R9
  count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wrap_cnt == '1) && !ack) |=> (wrap_cnt == '1));

  // R8
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(status && ien)));
endmodule

bind interval_tick_timer itt_checker #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .ack(ack),
  .run_en(run_en), .ien(ien), .status(status), .cur_val(cur_val),
  .limit(limit), .wrap_cnt(wrap_cnt), .irq(irq)
);

// File: tb/tb_interval_tick_timer.sv
module tb_interval_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_MODE = 4'h0, A_STAT = 4'h4, A_VAL = 4'h8, A_IMG = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string req = "R1";

  // Behavioural reference state
  int  m_pre, m_cur, m_cnt, m_piv;
  bit  m_en, m_ien, m_st, m_irq;

  interval_tick_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    if (!bus_rd || a[1:0] != 2'b00) return 32'h0;
    case (a)
      A_MODE:  return {6'd0, m_ien, m_en, 4'd0, m_piv[19:0]};
      A_STAT:  return {31'd0, m_st};
      default: return {m_cnt[11:0], m_cur[19:0]};
    endcase
  endfunction

  function automatic bit wrap_due();
    return (m_en || m_cur != 0) && m_pre == 15 && m_cur >= m_piv;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cur = 0; m_cnt = 0; m_piv = 0;
      m_en = 0; m_ien = 0; m_st = 0; m_irq = 0;
    end else begin
      bit run, en_set, tk, wr, ack, wmode;
      int n_pre, n_cur, n_cnt;
      bit n_st;
      run    = m_en || (m_cur != 0);
      wmode  = bus_wr && bus_addr == A_MODE;
      en_set = wmode && bus_wdata[24] && !m_en;
      tk     = run && m_pre == 15;
      wr     = tk && m_cur >= m_piv;
      ack    = bus_rd && bus_addr == A_VAL;
      n_pre  = (!run || en_set) ? 0 : (m_pre + 1) % 16;
      n_cur  = wr ? 0 : (tk ? m_cur + 1 : m_cur);
      n_st = m_st; n_cnt = m_cnt;
      if (wr) begin
        n_st = 1;
        n_cnt = ack ? 1 : (m_cnt < 4095 ? m_cnt + 1 : 4095);
      end else if (ack) begin
        n_st = 0; n_cnt = 0;
      end
      m_irq = m_st && m_ien;
      if (wmode) begin
        m_piv = int'(bus_wdata[19:0]); m_en = bus_wdata[24]; m_ien = bus_wdata[25];
      end
      m_pre = n_pre; m_cur = n_cur; m_cnt = n_cnt; m_st = n_st;
    end
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check_eq({req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
      check_eq({req, " rdata"}, bus_rdata, model_read(bus_addr));
    end
  end

  task automatic cyc(input bit w, input bit r, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 32'h0);
  endtask

  function automatic logic [31:0] mode(input int piv, input bit en, input bit ie);
    return {6'd0, ie, en, 4'd0, 20'(piv)};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    req = "R1";
    cyc(0, 1, A_MODE, 0); #1 check_eq("R1 mode", bus_rdata, 32'h0);
    cyc(0, 1, A_STAT, 0); #1 check_eq("R1 status", bus_rdata, 32'h0);
    cyc(0, 1, A_IMG, 0);  #1 check_eq("R1 image", bus_rdata, 32'h0);
    check_eq("R1 irq", {31'd0, irq}, 32'h0);

    // R2: mode layout and readback
    req = "R2";
    cyc(1, 0, A_MODE, 32'hFCF0_0004 | mode(4, 1, 1));
    cyc(0, 1, A_MODE, 0); #1 check_eq("R2 mode", bus_rdata, mode(4, 1, 1));

    // R3: first advance 16 clocks after enabling write
    req = "R3";
    idle(14);
    cyc(0, 1, A_IMG, 0); #1 check_eq("R3 before tick", bus_rdata, 32'h0);
    cyc(0, 1, A_IMG, 0); #1 check_eq("R3 first tick", bus_rdata, 32'h1);

    // R4 / R5 / R7 / R8: periods with interrupt, image reads only
    req = "R4";
    idle(200);
    req = "R5";
    for (int i = 0; i < 40; i++) cyc(0, 1, A_IMG, 0);
    req = "R7";
    cyc(0, 1, A_STAT, 0); #1 check_eq("R7 sticky", bus_rdata, 32'h1);
    req = "R8";
    idle(5);
    check_eq("R8 irq high", {31'd0, irq}, 32'h1);

    // R6: acknowledge clears, image does not
    req = "R6";
    cyc(0, 1, A_VAL, 0);
    cyc(0, 1, A_STAT, 0); #1 check_eq("R6 ack clears", bus_rdata, 32'h0);
    idle(100);
    cyc(0, 1, A_IMG, 0); cyc(0, 1, A_IMG, 0); cyc(0, 1, A_STAT, 0);
    #1 check_eq("R6 image no effect", bus_rdata, 32'h1);

    // R8: interrupt masked
    req = "R8";
    cyc(1, 0, A_MODE, mode(4, 1, 0));
    idle(100);
    check_eq("R8 masked", {31'd0, irq}, 32'h0);

    // R10: acknowledge on the wrap edge
    req = "R10";
    cyc(0, 1, A_VAL, 0);
    begin
      bit hit = 0;
      while (!hit) begin
        @(negedge clk);
        if (wrap_due()) begin
          bus_rd = 1; bus_addr = A_VAL; hit = 1;
        end else begin
          bus_rd = 0;
        end
      end
    end
    cyc(0, 1, A_IMG, 0); #1 check_eq("R10 count one", {20'd0, bus_rdata[31:20]}, 32'h1);
    cyc(0, 1, A_STAT, 0); #1 check_eq("R10 status kept", bus_rdata, 32'h1);

    // R4: limit lowered below current value
    req = "R4";
    cyc(1, 0, A_MODE, mode(20, 1, 1));
    idle(16 * 12);
    cyc(1, 0, A_MODE, mode(3, 1, 1));
    idle(40);

    // R12: writes to read-only registers and unaligned access
    req = "R12";
    cyc(1, 0, A_STAT, 32'hFFFF_FFFF);
    cyc(1, 0, A_VAL, 32'hFFFF_FFFF);
    cyc(1, 0, A_IMG, 32'hFFFF_FFFF);
    cyc(1, 0, 4'h1, 32'h0);
    cyc(0, 1, 4'h9, 0); #1 check_eq("R12 unaligned", bus_rdata, 32'h0);
    cyc(0, 0, A_MODE, 0); #1 check_eq("R12 no read", bus_rdata, 32'h0);
    cyc(0, 1, A_MODE, 0); #1 check_eq("R12 mode kept", bus_rdata, mode(3, 1, 1));

    // R11: graceful stop
    req = "R11";
    cyc(1, 0, A_MODE, mode(9, 1, 1));
    idle(16 * 15);
    cyc(1, 0, A_MODE, mode(9, 0, 1));
    idle(16 * 12);
    cyc(0, 1, A_IMG, 0); #1 check_eq("R11 stopped", {12'd0, bus_rdata[19:0]}, 32'h0);
    idle(100);
    cyc(0, 1, A_IMG, 0); #1 check_eq("R11 holds", {12'd0, bus_rdata[19:0]}, 32'h0);
    cyc(1, 0, A_MODE, mode(2, 1, 1));
    idle(16 * 4);

    // R9: saturation with period of one tick
    req = "R9";
    cyc(1, 0, A_MODE, mode(0, 1, 0));
    cyc(0, 1, A_VAL, 0);
    idle(16 * 4110);
    cyc(0, 1, A_IMG, 0); #1 check_eq("R9 saturated", {20'd0, bus_rdata[31:20]}, 32'd4095);

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule